// File: doc/BRIEF.md
# SONET Frame-Position Confirmation Monitor

This block sits behind a byte-wide SONET receive path running at the 19.44 MHz byte rate. An upstream serial-to-parallel stage supplies a one-cycle marker pulse that claims to show where the framing pattern sits in the byte stream. The block does not search for the pattern on its own. It takes the marked position as a candidate and checks it exactly one frame (2430 byte clocks) later. It leaves the out-of-frame state only when all six framing bytes appear where the candidate predicts, and only if no stray marker arrived in the meantime.

The framing pattern is three 0xF6 bytes followed by three 0x28 bytes. A configuration input tells the block whether the marker lines up with the first 0xF6 byte or the first 0x28 byte. Once the block is in frame, it holds that state until reset. It then produces a one-cycle strobe at the start of every frame, in the cycle that carries the first 0xF6 byte.

Top module: `ifd_monitor`

## Requirements
- R1: After reset, `out_of_frame` is 1 and `frame_strobe` is 0, whatever state the block held before the reset.
- R2: With `mark_on_a2`=0, a marker in cycle P means the byte in cycle P is the first 0xF6. If cycles P+2430 to P+2432 carry 0xF6 and cycles P+2433 to P+2435 carry 0x28, then `out_of_frame` is 0 from cycle P+2436 on.
- R3: With `mark_on_a2`=1, a marker in cycle P means the byte in cycle P is the first 0x28, so the pattern window starts three bytes earlier. If cycles P+2427 to P+2429 carry 0xF6 and cycles P+2430 to P+2432 carry 0x28, then `out_of_frame` is 0 from cycle P+2433 on.
- R4: If any byte in the confirming window differs from the expected value, `out_of_frame` stays 1 and the candidate is dropped. The next marker after the failing cycle starts a new candidate.
- R5: A marker that arrives after a candidate's marker but before declaration, at any position other than the expected one in the confirming frame, cancels that candidate. That marker becomes the new candidate.
- R6: A marker at the expected position in the confirming frame does not change the outcome, and neither does the absence of that marker.
- R7: While in frame, `frame_strobe` is 1 for exactly one cycle per 2430 cycles. It is 1 in each cycle whose byte is the first 0xF6 of a frame. With `mark_on_a2`=0 those are cycles P+2430·k for k≥2.
- R8: Once `out_of_frame` falls, it stays 0 until reset. Markers and data contents no longer affect either output.
- R9: `frame_strobe` stays 0 while `out_of_frame` is 1.
- R10: Without any marker, `out_of_frame` stays 1 even when the stream carries correct framing patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously and is released synchronously inside the block |
| rx_byte | input | 8 | Received byte, one per clock |
| frame_mark | input | 1 | One-cycle marker for the candidate framing position |
| mark_on_a2 | input | 1 | 0: the marker flags the first 0xF6 byte. 1: the marker flags the first 0x28 byte |
| out_of_frame | output | 1 | 1 until in-frame is declared |
| frame_strobe | output | 1 | One-cycle pulse on the first 0xF6 byte of each frame while in frame |

## Verification
Both results are decoded from registers, so each has a fixed lag from the stimulus:
- `out_of_frame` falls one clock after the last 0x28 byte of the confirming frame, because the declaring byte is registered into the state at that edge.
- `frame_strobe` is high in the same cycle that presents the first 0xF6 byte, because it comes from the position counter and not from the data.

The bench keeps to these lags as follows:
- It numbers the cycles from the end of reset and computes, for every cycle, the expected value of both outputs from the marker cycle and the required offsets.
- It samples on the falling edge, before it drives that cycle's byte and marker.
- It checks the cycle just before declaration and the declaration cycle on their own.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // no candidate, counter frozen
    ST_ARMED = 2'd1,  // candidate taken, waiting for the confirming frame
    ST_CHECK = 2'd2,  // comparing the confirming frame's framing bytes
    ST_LOCK  = 2'd3   // in frame
  } ifd_state_e;
endpackage

// File: rtl/ifd_reset_sync.sv
module ifd_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  assign sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ifd_pos_counter.sv
module ifd_pos_counter #(
  parameter int FRAME_LEN = 2430,
  parameter int CW        = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,      // current byte sits at load_pos
  input  logic [CW-1:0] load_pos,
  input  logic          adv,       // clock enable for free running
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  function automatic logic [CW-1:0] step(input logic [CW-1:0] p);
    return (p == LAST) ? '0 : p + CW'(1);
  endfunction

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = step(load_pos);
    else if (adv) cnt_d = step(cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R7: the position never leaves one frame
  assert_cnt_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/ifd_pattern_match.sv
module ifd_pattern_match #(
  parameter logic [7:0] A1_VAL  = 8'hF6,
  parameter logic [7:0] A2_VAL  = 8'h28,
  parameter int         RUN_LEN = 3,
  parameter int         CW      = 12
) (
  input  logic [CW-1:0] pos,
  input  logic [7:0]    byte_in,
  output logic          in_win,
  output logic          hit
);
  localparam int WIN   = 2 * RUN_LEN;
  localparam int IW    = $clog2(WIN);
  localparam int DEPTH = 1 << IW;

  logic [7:0] exp_tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_exp
    if (g < RUN_LEN) begin : g_a1
      assign exp_tbl[g] = A1_VAL;
    end else if (g < WIN) begin : g_a2
      assign exp_tbl[g] = A2_VAL;
    end else begin : g_pad
      assign exp_tbl[g] = '0;
    end
  end

  assign in_win = (pos < CW'(WIN));
  assign hit    = in_win && (byte_in == exp_tbl[pos[IW-1:0]]);
endmodule

// File: rtl/ifd_ctrl.sv
module ifd_ctrl
  import ifd_pkg::*;
#(
  parameter int FRAME_LEN = 2430,
  parameter int RUN_LEN   = 3,
  parameter int CW        = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_mark,
  input  logic          mark_on_a2,
  input  logic [CW-1:0] cnt,
  input  logic          in_win,
  input  logic          hit,
  output logic          load,
  output logic [CW-1:0] load_pos,
  output logic          adv,
  output logic [CW-1:0] pos_cur,
  output logic          out_of_frame,
  output logic          frame_strobe
);
  localparam logic [CW-1:0] LAST    = CW'(FRAME_LEN - 1);
  localparam logic [CW-1:0] WIN_END = CW'(2 * RUN_LEN - 1);

  ifd_state_e    state_q;
  ifd_state_e    state_d;
  logic [CW-1:0] off;
  logic          stray;

  assign off      = mark_on_a2 ? CW'(RUN_LEN) : '0;
  assign load_pos = off;
  assign pos_cur  = (state_q == ST_IDLE) ? off : cnt;
  assign stray    = frame_mark && !((state_q == ST_CHECK) && (cnt == off));

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    adv     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (frame_mark) begin
          load    = 1'b1;
          state_d = ST_ARMED;
        end
      end
      ST_ARMED: begin
        adv = 1'b1;
        if (frame_mark)       load    = 1'b1;
        else if (cnt == LAST) state_d = ST_CHECK;
      end
      ST_CHECK: begin
        adv = 1'b1;
        if (stray) begin
          load    = 1'b1;
          state_d = ST_ARMED;
        end else if (in_win && !hit) begin
          state_d = ST_IDLE;
        end else if (cnt == WIN_END) begin
          state_d = ST_LOCK;
        end
      end
      ST_LOCK: adv = 1'b1;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign out_of_frame = (state_q != ST_LOCK);
  assign frame_strobe = (state_q == ST_LOCK) && (cnt == '0);

  // R2: leaving out-of-frame happens right after the last framing byte
  assert_lock_after_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_of_frame) |-> (cnt == CW'(2 * RUN_LEN)));

  // R4: a wrong framing byte never leads to declaration
  assert_mismatch_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_CHECK) && in_win && !hit) |=> out_of_frame);

  // R5: a stray marker re-arms and keeps out-of-frame
  assert_stray_rearms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q inside {ST_ARMED, ST_CHECK}) && stray) |=> (out_of_frame && (state_q == ST_ARMED)));

  // R7: the frame strobe lasts one cycle
  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> !frame_strobe);

  // R8: in-frame holds until reset
  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_of_frame |=> !out_of_frame);
endmodule

// File: rtl/ifd_monitor.sv
module ifd_monitor #(
  parameter int         FRAME_LEN   = 2430,
  parameter logic [7:0] A1_VAL      = 8'hF6,
  parameter logic [7:0] A2_VAL      = 8'h28,
  parameter int         RUN_LEN     = 3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] rx_byte,
  input  logic       frame_mark,
  input  logic       mark_on_a2,
  output logic       out_of_frame,
  output logic       frame_strobe
);
  localparam int CW = $clog2(FRAME_LEN);

  logic          rst_core_n;
  logic [CW-1:0] cnt;
  logic [CW-1:0] load_pos;
  logic [CW-1:0] pos_cur;
  logic          load;
  logic          adv;
  logic          in_win;
  logic          hit;

  ifd_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  ifd_pos_counter #(.FRAME_LEN(FRAME_LEN), .CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (load),
    .load_pos (load_pos),
    .adv      (adv),
    .cnt      (cnt)
  );

  ifd_pattern_match #(.A1_VAL(A1_VAL), .A2_VAL(A2_VAL), .RUN_LEN(RUN_LEN), .CW(CW)) u_match (
    .pos     (pos_cur),
    .byte_in (rx_byte),
    .in_win  (in_win),
    .hit     (hit)
  );

  ifd_ctrl #(.FRAME_LEN(FRAME_LEN), .RUN_LEN(RUN_LEN), .CW(CW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .frame_mark   (frame_mark),
    .mark_on_a2   (mark_on_a2),
    .cnt          (cnt),
    .in_win       (in_win),
    .hit          (hit),
    .load         (load),
    .load_pos     (load_pos),
    .adv          (adv),
    .pos_cur      (pos_cur),
    .out_of_frame (out_of_frame),
    .frame_strobe (frame_strobe)
  );
endmodule

// File: tb/ifd_monitor_tb_top.sv
module ifd_monitor_tb_top;
  localparam int F = 2430;

  logic       clk;
  logic       rst_n;
  logic [7:0] rx_byte;
  logic       frame_mark;
  logic       mark_on_a2;
  logic       out_of_frame;
  logic       frame_strobe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ifd_monitor dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_byte      (rx_byte),
    .frame_mark   (frame_mark),
    .mark_on_a2   (mark_on_a2),
    .out_of_frame (out_of_frame),
    .frame_strobe (frame_strobe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // byte at stream position ph (0 = first 0xF6)
  function automatic logic [7:0] stream_byte(input int ph);
    if (ph < 3)      return 8'hF6;
    else if (ph < 6) return 8'h28;
    else             return 8'($urandom);
  endfunction

  // lock_c: first cycle with out_of_frame expected low
  task automatic run_scen(input string req, input bit sel, input int s0, input int pstart,
                          input bit once, input int xc, input int cc, input int lock_c,
                          input int ncyc);
    int mark     = sel ? 3 : 0;
    int sent     = 0;
    int bad_oof  = -1;
    int bad_fs   = -1;
    rst_n      = 1'b0;
    frame_mark = 1'b0;
    rx_byte    = 8'h00;
    mark_on_a2 = sel;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int c = 0; c < ncyc; c++) begin
      int   ph;
      bit   exp_oof;
      bit   exp_fs;
      logic [7:0] b;
      bit   p;
      if (c > 0) @(negedge clk);
      ph      = (c + s0) % F;
      exp_oof = (c < lock_c);
      exp_fs  = (c >= lock_c) && (ph == 0);
      if (c == 0) begin
        check("R1", "oof after reset", int'(out_of_frame), 1);
        check("R1", "strobe after reset", int'(frame_strobe), 0);
      end
      if (c == lock_c - 1) check(req, "oof one cycle before declaration", int'(out_of_frame), 1);
      if (c == lock_c)     check(req, "oof at declaration cycle", int'(out_of_frame), 0);
      if (out_of_frame !== exp_oof && bad_oof < 0) bad_oof = c;
      if (frame_strobe !== exp_fs && bad_fs < 0)   bad_fs  = c;
      b = stream_byte(ph);
      if (c == cc) b = ~b;
      p = 1'b0;
      if (c >= pstart && ph == mark && !(once && sent > 0)) begin
        p = 1'b1;
        sent++;
      end
      if (c == xc) p = 1'b1;
      rx_byte    = b;
      frame_mark = p;
    end
    check(req, "first cycle with wrong oof", bad_oof, -1);
    check("R7 R9", "first cycle with wrong strobe", bad_fs, -1);
    @(negedge clk);
    frame_mark = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd5219));
    rst_n = 1'b0; frame_mark = 1'b0; rx_byte = 8'h00; mark_on_a2 = 1'b0;
    // R2 R6 R7: first-A1 marking, markers every frame
    run_scen("R2", 1'b0, F-10, 0, 1'b0, -1, -1, 16+F, 3*F+20);
    // R3: first-A2 marking
    run_scen("R3", 1'b1, F-10, 0, 1'b0, -1, -1, 16+F, 3*F+20);
    // R6: single marker, none in the confirming frame
    run_scen("R6", 1'b0, F-10, 0, 1'b1, -1, -1, 16+F, 3*F+20);
    // R4: corrupt second A2 in the confirming window, first-A1 marking
    run_scen("R4", 1'b0, F-10, 0, 1'b0, -1, 14+F, 16+3*F, 4*F+20);
    // R4: corrupt an A1 byte, first-A2 marking; next marker follows at once
    run_scen("R4", 1'b1, F-10, 0, 1'b0, -1, 11+F, 16+2*F, 3*F+20);
    // R5: stray marker while armed
    run_scen("R5", 1'b0, F-10, 0, 1'b0, 500, -1, 16+2*F, 3*F+20);
    // R5: stray marker inside the confirming window
    run_scen("R5", 1'b1, F-10, 0, 1'b0, 11+F, -1, 16+2*F, 3*F+20);
    // R10: correct patterns but no marker at all
    run_scen("R10", 1'b0, F-10, 1<<30, 1'b0, -1, -1, 1<<30, 2*F);
    // R8: stray marker and corrupt framing byte after lock
    run_scen("R8", 1'b0, F-10, 0, 1'b0, 3000, 12+2*F, 16+F, 3*F+20);
    // random phase and marking mode
    for (int i = 0; i < 3; i++) begin
      bit sel  = 1'($urandom);
      int s0   = int'($urandom % F);
      int mark = sel ? 3 : 0;
      int pc   = (mark - s0 + F) % F;
      run_scen(sel ? "R3" : "R2", sel, s0, 0, 1'b0, -1, -1, pc + F + 6 - mark, pc + 3*F + 20);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule